// File: doc/BRIEF.md
# Grouped Pin-Toggle Interrupt Unit

This block watches thirteen general-purpose pins and raises an interrupt when any selected pin changes level. The pins are split into two groups: the low eight pins (indices 7 down to 0) belong to group 0 and the high five pins (indices 12 down to 8) belong to group 1. Each group has its own pin-select mask, a sticky event flag, an enable bit and one request output. The pins are sampled whether the chip drives them or not, so software can raise an event by driving a pin it owns.

A rising or a falling level counts as a toggle. In normal operation the pins pass through a two-stage synchronizer and each synchronized value is compared with its value one clock earlier. While the system clock is stopped, a clockless comparison against the last sampled pin values drives a wake output. This lets a pin change bring the part out of a deep sleep. Once the clock runs again, the same change is seen by the synchronizer and sets the group flag in the usual way.

Software reaches the masks, the enable bits and the flags through a small register port. Writes and reads take one address each, and reads are combinational. A flag is cleared by writing a 1 to its bit or by pulsing that group's acknowledge input.

Top module: `pin_toggle_irq`

## Requirements
- R1: After reset, both masks, both group enables and both flags read 0, and `irq_o` and `wake_o` are 0.
- R2: The register map is as follows. Address 0 holds the group enables in bits [1:0] (bit g enables group g). Address 1 holds the flags in bits [1:0]. Address 2 holds the group 0 mask, where bit k selects pin k. Address 3 holds the group 1 mask in bits [4:0], and bits [7:5] of address 3 read 0.
- R3: A rising or falling change on a group 0 pin whose mask bit is 1 sets flag bit 0 no later than the third rising clock edge after the change.
- R4: A change on pin k of group 1 (k in 12..8) sets flag bit 1 when mask bit k-8 at address 3 is 1.
- R5: A change on a pin whose mask bit is 0 leaves both flags unchanged.
- R6: A flag is set regardless of its group enable. `irq_o[g]` is high exactly when flag g, enable g and `irq_glb_en_i` are all high.
- R7: Writing 1 to a flag bit at address 1 clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R8: A high `ack_i[g]` at a rising clock edge clears flag g.
- R9: If a new toggle and a clear (a write or an acknowledge) reach the same flag at the same edge, the flag ends up set.
- R10: Clearing a mask bit does not clear a flag that is already set.
- R11: While `clk_gated_i` is high, a change on a selected pin of an enabled group raises `wake_o` with no clock edge needed. `wake_o` is 0 whenever `clk_gated_i` is 0, and it does not depend on `irq_glb_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, stopped while gated |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 13 | Watched pin levels |
| clk_gated_i | input | 1 | High while the clock is stopped for sleep |
| irq_glb_en_i | input | 1 | Global interrupt enable |
| ack_i | input | 2 | Per-group flag acknowledge |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_o | output | 2 | Per-group interrupt request |
| wake_o | output | 1 | Clockless wake request |

## Verification
The hardest case to reach from the ports is the collision in R9, where a toggle and a clear arrive at the same flag at the same edge. The stimulus changes a pin on a falling edge and counts exactly two rising edges through the synchronizer. It then holds the acknowledge across the third edge, which is the one at which the toggle is detected. The wake path is hard in a different way: the bench really stops its clock, changes pins with no edges present, and only later restarts the clock to confirm that the flag catches up.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int G0_W   = 8;
  localparam int G1_W   = 5;
  localparam int NGRP   = 2;
  localparam int RAW    = 2;
  localparam int RDW    = 8;
  localparam int SYNC_N = 2;

  typedef enum logic [RAW-1:0] {
    RA_GRP_EN = 2'd0,
    RA_FLAGS  = 2'd1,
    RA_MASK0  = 2'd2,
    RA_MASK1  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pct_sync.sv
module pct_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/pct_group.sv
module pct_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s_i,
  input  logic [W-1:0] pin_raw_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  output logic         hit_o,
  output logic         flag_o,
  output logic         wake_hit_o
);
  logic [W-1:0] prev_q;
  logic         flag_q;

  // sampled edge detect and clockless compare against last sample
  assign hit_o      = |((pin_s_i ^ prev_q) & mask_i);
  assign wake_hit_o = |((pin_raw_i ^ prev_q) & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      if (hit_o)      flag_q <= 1'b1;  // new event beats a clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pct_regs.sv
module pct_regs
  import pct_pkg::*;
#(
  parameter int M0_W = G0_W,
  parameter int M1_W = G1_W,
  parameter int NG   = NGRP,
  parameter int AW   = RAW,
  parameter int DW   = RDW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NG-1:0] flags_i,
  output logic [DW-1:0] rdata_o,
  output logic [M0_W-1:0] mask0_o,
  output logic [M1_W-1:0] mask1_o,
  output logic [NG-1:0] grp_en_o,
  output logic [NG-1:0] wclr_o
);
  logic [M0_W-1:0] mask0_q;
  logic [M1_W-1:0] mask1_q;
  logic [NG-1:0]   en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask0_q <= '0;
      mask1_q <= '0;
      en_q    <= '0;
    end else if (wr_i) begin
      case (reg_addr_e'(addr_i))
        RA_GRP_EN: en_q    <= wdata_i[NG-1:0];
        RA_MASK0:  mask0_q <= wdata_i[M0_W-1:0];
        RA_MASK1:  mask1_q <= wdata_i[M1_W-1:0];
        default:   ;
      endcase
    end
  end

  assign wclr_o = (wr_i && reg_addr_e'(addr_i) == RA_FLAGS) ? wdata_i[NG-1:0] : '0;

  always_comb begin
    case (reg_addr_e'(addr_i))
      RA_GRP_EN: rdata_o = {{(DW-NG){1'b0}}, en_q};
      RA_FLAGS:  rdata_o = {{(DW-NG){1'b0}}, flags_i};
      RA_MASK0:  rdata_o = {{(DW-M0_W){1'b0}}, mask0_q};
      default:   rdata_o = {{(DW-M1_W){1'b0}}, mask1_q};
    endcase
  end

  assign mask0_o  = mask0_q;
  assign mask1_o  = mask1_q;
  assign grp_en_o = en_q;
endmodule

// File: rtl/pin_toggle_irq.sv
module pin_toggle_irq
  import pct_pkg::*;
#(
  parameter int W0     = G0_W,
  parameter int W1     = G1_W,
  parameter int STAGES = SYNC_N,
  parameter int AW     = RAW,
  parameter int DW     = RDW,
  localparam int PW    = W0 + W1,
  localparam int NG    = NGRP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pins_i,
  input  logic          clk_gated_i,
  input  logic          irq_glb_en_i,
  input  logic [NG-1:0] ack_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic [NG-1:0] irq_o,
  output logic          wake_o
);
  logic [PW-1:0] pins_s;
  logic [W0-1:0] mask0;
  logic [W1-1:0] mask1;
  logic [NG-1:0] grp_en, wclr, flag_q, grp_hit, wake_hit;

  pct_sync #(.W(PW), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(pins_s)
  );

  pct_regs #(.M0_W(W0), .M1_W(W1), .NG(NG), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .flags_i(flag_q), .rdata_o(reg_rdata_o),
    .mask0_o(mask0), .mask1_o(mask1), .grp_en_o(grp_en), .wclr_o(wclr)
  );

  pct_group #(.W(W0)) u_grp0 (
    .clk(clk), .rst_n(rst_n),
    .pin_s_i(pins_s[W0-1:0]), .pin_raw_i(pins_i[W0-1:0]), .mask_i(mask0),
    .clr_i(wclr[0] | ack_i[0]),
    .hit_o(grp_hit[0]), .flag_o(flag_q[0]), .wake_hit_o(wake_hit[0])
  );

  pct_group #(.W(W1)) u_grp1 (
    .clk(clk), .rst_n(rst_n),
    .pin_s_i(pins_s[PW-1:W0]), .pin_raw_i(pins_i[PW-1:W0]), .mask_i(mask1),
    .clr_i(wclr[1] | ack_i[1]),
    .hit_o(grp_hit[1]), .flag_o(flag_q[1]), .wake_hit_o(wake_hit[1])
  );

  assign irq_o  = flag_q & grp_en & {NG{irq_glb_en_i}};
  assign wake_o = clk_gated_i & |(wake_hit & grp_en);
endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
  parameter int NG = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_gated_i,
  input logic          irq_glb_en_i,
  input logic [NG-1:0] ack_i,
  input logic [NG-1:0] irq_o,
  input logic          wake_o,
  input logic [NG-1:0] flag_q,
  input logic [NG-1:0] grp_hit
);
  p_flag0_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(grp_hit[0]));

  p_flag1_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> $past(grp_hit[1]));

  p_irq_global_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> irq_glb_en_i);

  p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] |-> flag_q[0]);

  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i[1] && !grp_hit[1]) |=> !flag_q[1]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grp_hit[0] |=> flag_q[0]);

  p_wake_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> clk_gated_i);
endmodule

bind pin_toggle_irq pct_checker #(.NG(2)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_gated_i(clk_gated_i),
  .irq_glb_en_i(irq_glb_en_i), .ack_i(ack_i), .irq_o(irq_o),
  .wake_o(wake_o), .flag_q(flag_q), .grp_hit(grp_hit)
);

// File: tb/sim_pin_toggle_irq.sv
`timescale 1ns/1ps
module sim_pin_toggle_irq;
  logic        clk = 1'b0;
  logic        clk_run = 1'b1;
  logic        rst_n = 1'b0;
  logic [12:0] pins = '0;
  logic        gated = 1'b0;
  logic        glb = 1'b0;
  logic [1:0]  ack = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  irq;
  logic        wake;
  int checks = 0;
  int errors = 0;

  always begin
    #2;
    if (clk_run) clk = ~clk;
    else clk = 1'b0;
  end

  pin_toggle_irq u0 (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .clk_gated_i(gated),
    .irq_glb_en_i(glb), .ack_i(ack), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick(1);
    wr = 1'b0;
  endtask

  task automatic rreg(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic clear_all();
    wreg(2'd1, 8'h03);
  endtask

  task automatic t_reset();
    rreg("R1 enables", 2'd0, 8'h00);
    rreg("R1 flags", 2'd1, 8'h00);
    rreg("R1 mask0", 2'd2, 8'h00);
    rreg("R1 mask1", 2'd3, 8'h00);
    check("R1 irq", {6'b0, irq}, 8'h00);
    check("R1 wake", {7'b0, wake}, 8'h00);
  endtask

  task automatic t_regs();
    wreg(2'd0, 8'hFF);
    wreg(2'd2, 8'hA5);
    wreg(2'd3, 8'hFF);
    rreg("R2 enables", 2'd0, 8'h03);
    rreg("R2 mask0", 2'd2, 8'hA5);
    rreg("R2 mask1 padding", 2'd3, 8'h1F);
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'h00);
    wreg(2'd3, 8'h00);
  endtask

  task automatic t_grp0();
    glb = 1'b1;
    wreg(2'd0, 8'h01);
    wreg(2'd2, 8'h04);
    pins[2] = 1'b1;
    tick(3);
    rreg("R3 rising sets flag0", 2'd1, 8'h01);
    check("R6 irq0 high", {6'b0, irq}, 8'h01);
    wreg(2'd1, 8'h00);
    rreg("R7 write 0 keeps flag", 2'd1, 8'h01);
    wreg(2'd1, 8'h01);
    rreg("R7 write 1 clears flag", 2'd1, 8'h00);
    pins[2] = 1'b0;
    tick(3);
    rreg("R3 falling sets flag0", 2'd1, 8'h01);
    ack = 2'b01;
    tick(1);
    ack = 2'b00;
    rreg("R8 ack clears flag0", 2'd1, 8'h00);
  endtask

  task automatic t_grp1();
    wreg(2'd3, 8'h08);
    pins[8] = 1'b1;
    tick(4);
    rreg("R5 masked group1 pin", 2'd1, 8'h00);
    pins[11] = 1'b1;
    tick(3);
    rreg("R4 pin 11 sets flag1", 2'd1, 8'h02);
    check("R6 irq1 low while group1 disabled", {6'b0, irq}, 8'h00);
    ack = 2'b10;
    tick(1);
    ack = 2'b00;
    rreg("R8 ack clears flag1", 2'd1, 8'h00);
  endtask

  task automatic t_masked();
    pins[5] = 1'b1;
    pins[0] = 1'b1;
    tick(4);
    rreg("R5 masked group0 pins", 2'd1, 8'h00);
  endtask

  task automatic t_enable();
    wreg(2'd0, 8'h00);
    pins[2] = 1'b1;
    tick(4);
    rreg("R6 flag set while disabled", 2'd1, 8'h01);
    check("R6 irq0 low while disabled", {6'b0, irq}, 8'h00);
    wreg(2'd0, 8'h01);
    glb = 1'b0;
    #1;
    check("R6 irq0 low without global", {6'b0, irq}, 8'h00);
    glb = 1'b1;
    #1;
    check("R6 irq0 high with all enables", {6'b0, irq}, 8'h01);
    wreg(2'd2, 8'h00);
    rreg("R10 mask clear keeps flag", 2'd1, 8'h01);
    wreg(2'd2, 8'h04);
    clear_all();
  endtask

  task automatic t_collide();
    pins[2] = 1'b0;
    tick(2);
    ack = 2'b01;
    tick(1);
    ack = 2'b00;
    rreg("R9 set wins over ack", 2'd1, 8'h01);
    clear_all();
    pins[2] = 1'b1;
    tick(2);
    wr = 1'b1; addr = 2'd1; wdata = 8'h01;
    tick(1);
    wr = 1'b0;
    rreg("R9 set wins over write clear", 2'd1, 8'h01);
    clear_all();
  endtask

  task automatic t_wake();
    wreg(2'd2, 8'h02);
    tick(1);
    clk_run = 1'b0;
    gated = 1'b1;
    glb = 1'b0;
    #5;
    check("R11 no wake without change", {7'b0, wake}, 8'h00);
    pins[6] = 1'b1;
    #5;
    check("R11 masked pin no wake", {7'b0, wake}, 8'h00);
    pins[1] = 1'b1;
    #5;
    check("R11 wake with clock stopped", {7'b0, wake}, 8'h01);
    gated = 1'b0;
    #1;
    check("R11 wake released", {7'b0, wake}, 8'h00);
    clk_run = 1'b1;
    tick(4);
    rreg("R11 flag after clock resumes", 2'd1, 8'h01);
    clear_all();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_regs();
    t_grp0();
    t_grp1();
    t_masked();
    t_enable();
    t_collide();
    t_wake();
    finish_run();
  end
endmodule